// File: doc/BRIEF.md
# Alias-Aware Line Invalidate Sequencer

This block turns one byte-range invalidate request for a virtually indexed, physically tagged instruction cache into a stream of per-line invalidate commands. A request carries a physical start address, a byte count and, optionally, a virtual address. The block widens the range outward to whole cache lines. It then walks the lines in ascending order and emits commands on a valid/ready port. Each command holds a tag word and an index word.

When no virtual address is known, the cache cannot tell which of several sets a physical line may sit in. The sequencer therefore emits one command per possible alias position. The number of positions is the way-size to page-size ratio, which is set when the block is elaborated. Two command encodings are available, chosen by a parameter. In split mode the tag word and the index word are separate. In packed mode the alias or virtual index bits travel in the line-offset bits of a single address, and the tag and index words are equal.

Top module: `inv_line_seq`

## Requirements
- R1: The range is aligned before the walk. The start is rounded down to a multiple of 2^LINE_SHIFT bytes. The line count is ceil((size + start mod line length) / line length). The last byte of the range is at start + size - 1, and no line past the one holding it is visited.
- R2: The number of commands per line depends on WAY_PAGE_RATIO when no virtual address is supplied. A ratio of 0 or 1 gives one command per line, 2 gives two and 4 gives four.
- R3: Split mode (PACKED_IDX=0), no virtual address: every command of a line has tag = line address. The index is the line address with bits [PAGE_SHIFT +: log2(ratio)] replaced by the variant number, counting 0,1,2,3 in that order.
- R4: Packed mode (PACKED_IDX=1), no virtual address: tag = index = line address OR variant number, with the variant counting up from 0.
- R5: With a virtual address supplied, each line gets exactly one command. In split mode, tag = line address and index = (virtual address rounded down to a line) + k × line length for the k-th line. In packed mode, tag = index = line address with virtual bits [PAGE_SHIFT+4:PAGE_SHIFT] placed in bits 4:0.
- R6: A zero-byte request issues no command and still produces a done pulse.
- R7: req_ready_o is high only when the block is idle. A request presented while the block is busy is ignored. While a command is pending, req_ready_o is low.
- R8: done_o is high for exactly one cycle. That cycle is the one after the handshake of the last command, or the one after acceptance for a request that issues no commands.
- R9: While cmd_valid_o is high and cmd_ready_i is low, the command stays valid and its tag and index do not change.
- R10: Any ratio other than 0, 1, 2 or 4 drives cfg_err_o high. In that case every request completes with done and issues no commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken on this cycle |
| req_paddr_i | input | ADDR_W | Physical start address |
| req_size_i | input | SIZE_W | Byte count, end exclusive |
| req_vaddr_valid_i | input | 1 | Virtual address is known |
| req_vaddr_i | input | ADDR_W | Virtual start address |
| cmd_valid_o | output | 1 | Command pending |
| cmd_ready_i | input | 1 | Command taken |
| cmd_tag_o | output | ADDR_W | Tag word |
| cmd_index_o | output | ADDR_W | Index word |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | Unsupported alias ratio |

## Verification
Three instances run side by side on the same requests: split mode with four aliases, packed mode with two, and an illegal ratio of three. The bench aims at ranges that end exactly on a line boundary and at ranges that spill into the next line by one byte. A design with an inclusive end would add a line in the first case; one that dropped the slack would lose a line in the second. Line addresses whose page-shift bits are already set show whether those bits are forced to the variant or only ORed with it. Command ports are stalled on irregular patterns, and a request is pulsed mid-run. A block that mutated a stalled command, accepted while busy, or signalled done before its last handshake shows up as a mismatch, an unexpected command or a non-empty queue at done.

// File: rtl/inv_seq_pkg.sv
package inv_seq_pkg;

  localparam int PACK_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  function automatic bit ratio_ok(input int r);
    return (r == 0) || (r == 1) || (r == 2) || (r == 4);
  endfunction

  function automatic int num_variants(input int r);
    return (r == 4) ? 4 : ((r == 2) ? 2 : 1);
  endfunction

  function automatic int alias_bits(input int r);
    return (r == 4) ? 2 : ((r == 2) ? 1 : 0);
  endfunction

endpackage

// File: rtl/inv_range_align.sv
module inv_range_align #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int LINE_SHIFT = 5,
  localparam int CNT_W     = SIZE_W + 2 - LINE_SHIFT
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  lines_o,
  output logic              empty_o
);
  localparam int TW = SIZE_W + 2;
  localparam logic [ADDR_W-1:0] LMASK = ADDR_W'((1 << LINE_SHIFT) - 1);

  logic [TW-1:0] total;
  logic          unused_lo;

  assign base_o    = addr_i & ~LMASK;
  // slack folded into the size, then ceiling divide
  assign total     = TW'(size_i) + TW'(addr_i[LINE_SHIFT-1:0]) + TW'((1 << LINE_SHIFT) - 1);
  assign lines_o   = total[TW-1:LINE_SHIFT];
  assign empty_o   = (size_i == '0);
  assign unused_lo = ^total[LINE_SHIFT-1:0];
endmodule

// File: rtl/inv_variant_gen.sv
module inv_variant_gen
  import inv_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int ALIAS_BITS = 2,
  parameter bit PACKED_IDX = 1'b0
) (
  input  logic [ADDR_W-1:0] line_i,
  input  logic [ADDR_W-1:0] vline_i,
  input  logic [PACK_W-1:0] vpack_i,
  input  logic              use_v_i,
  input  logic [1:0]        var_i,
  output logic [ADDR_W-1:0] tag_o,
  output logic [ADDR_W-1:0] index_o
);
  generate
    if (PACKED_IDX) begin : g_packed
      logic unused_vline;
      assign unused_vline = ^vline_i;
      assign index_o = use_v_i ? (line_i | ADDR_W'(vpack_i))
                               : (line_i | ADDR_W'(var_i));
      assign tag_o   = index_o;
    end else begin : g_split
      localparam logic [ADDR_W-1:0] AB_MASK =
        ((ADDR_W'(1) << ALIAS_BITS) - ADDR_W'(1)) << PAGE_SHIFT;
      logic unused_vpack;
      assign unused_vpack = ^vpack_i;
      assign tag_o   = line_i;
      assign index_o = use_v_i ? vline_i
                               : ((line_i & ~AB_MASK) |
                                  ((ADDR_W'(var_i) << PAGE_SHIFT) & AB_MASK));
    end
  endgenerate
endmodule

// File: rtl/inv_step_ctrl.sv
module inv_step_ctrl
  import inv_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 13,
  parameter int LINE_SHIFT = 5,
  parameter int PAGE_SHIFT = 13,
  parameter int NUM_VAR    = 4,
  parameter bit CFG_OK     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  lines_i,
  input  logic              empty_i,
  input  logic              vaddr_valid_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] line_o,
  output logic [ADDR_W-1:0] vline_o,
  output logic [PACK_W-1:0] vpack_o,
  output logic              use_v_o,
  output logic [1:0]        var_o
);
  localparam logic [ADDR_W-1:0] LINE_BYTES = ADDR_W'(1) << LINE_SHIFT;
  localparam logic [ADDR_W-1:0] LMASK      = LINE_BYTES - ADDR_W'(1);
  localparam logic [1:0]        LAST_VAR   = 2'(NUM_VAR - 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] line_q, vline_q;
  logic [PACK_W-1:0] vpack_q;
  logic              use_v_q;
  logic [1:0]        var_q;
  logic [CNT_W-1:0]  left_q;
  logic              last_var;

  assign last_var = use_v_q || (var_q == LAST_VAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      vline_q <= '0;
      vpack_q <= '0;
      use_v_q <= 1'b0;
      var_q   <= '0;
      left_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          line_q  <= base_i;
          vline_q <= vaddr_i & ~LMASK;
          vpack_q <= vaddr_i[PAGE_SHIFT +: PACK_W];
          use_v_q <= vaddr_valid_i;
          var_q   <= '0;
          left_q  <= lines_i;
          state_q <= (empty_i || !CFG_OK) ? ST_DONE : ST_RUN;
        end
        ST_RUN: if (cmd_ready_i) begin
          if (last_var) begin
            var_q   <= '0;
            line_q  <= line_q + LINE_BYTES;
            vline_q <= vline_q + LINE_BYTES;
            left_q  <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) state_q <= ST_DONE;
          end else begin
            var_q <= var_q + 2'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign cmd_valid_o = (state_q == ST_RUN);
  assign done_o      = (state_q == ST_DONE);
  assign line_o      = line_q;
  assign vline_o     = vline_q;
  assign vpack_o     = vpack_q;
  assign use_v_o     = use_v_q;
  assign var_o       = var_q;
endmodule

// File: rtl/inv_line_seq.sv
module inv_line_seq
  import inv_seq_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int SIZE_W         = 16,
  parameter int LINE_SHIFT     = 5,
  parameter int PAGE_SHIFT     = 13,
  parameter int WAY_PAGE_RATIO = 4,
  parameter bit PACKED_IDX     = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_paddr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic              req_vaddr_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [ADDR_W-1:0] cmd_tag_o,
  output logic [ADDR_W-1:0] cmd_index_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  localparam bit CFG_OK  = ratio_ok(WAY_PAGE_RATIO);
  localparam int NUM_VAR = num_variants(WAY_PAGE_RATIO);
  localparam int AB      = alias_bits(WAY_PAGE_RATIO);
  localparam int CNT_W   = SIZE_W + 2 - LINE_SHIFT;

  logic [ADDR_W-1:0] base, line, vline;
  logic [CNT_W-1:0]  lines;
  logic              empty, use_v;
  logic [PACK_W-1:0] vpack;
  logic [1:0]        var_idx;

  assign cfg_err_o = !CFG_OK;

  inv_range_align #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_SHIFT(LINE_SHIFT)
  ) u_align (
    .addr_i(req_paddr_i), .size_i(req_size_i),
    .base_o(base), .lines_o(lines), .empty_o(empty)
  );

  inv_step_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_SHIFT(LINE_SHIFT),
    .PAGE_SHIFT(PAGE_SHIFT), .NUM_VAR(NUM_VAR), .CFG_OK(CFG_OK)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .base_i(base), .lines_i(lines), .empty_i(empty),
    .vaddr_valid_i(req_vaddr_valid_i), .vaddr_i(req_vaddr_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .done_o(done_o),
    .line_o(line), .vline_o(vline), .vpack_o(vpack),
    .use_v_o(use_v), .var_o(var_idx)
  );

  inv_variant_gen #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .ALIAS_BITS(AB), .PACKED_IDX(PACKED_IDX)
  ) u_vgen (
    .line_i(line), .vline_i(vline), .vpack_i(vpack), .use_v_i(use_v),
    .var_i(var_idx), .tag_o(cmd_tag_o), .index_o(cmd_index_o)
  );
endmodule

// File: rtl/inv_line_seq_chk.sv
module inv_line_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [ADDR_W-1:0] cmd_tag_o,
  input logic [ADDR_W-1:0] cmd_index_o,
  input logic              done_o,
  input logic              cfg_err_o
);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_tag_o) && $stable(cmd_index_o));

  p_done_after_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cmd_valid_o && cmd_ready_i) || $past(req_valid_i && req_ready_o));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_no_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !req_ready_o);

  p_accept_leaves_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  p_err_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !cmd_valid_o);
endmodule

bind inv_line_seq inv_line_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
  .cmd_tag_o(cmd_tag_o), .cmd_index_o(cmd_index_o),
  .done_o(done_o), .cfg_err_o(cfg_err_o)
);

// File: tb/inv_line_seq_tb.sv
module inv_line_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_paddr = '0;
  logic [15:0] req_size = '0;
  logic        req_vv = 1'b0;
  logic [31:0] req_vaddr = '0;

  logic        sp_rdy_req, pk_rdy_req, bd_rdy_req;
  logic        sp_valid, pk_valid, bd_valid;
  logic        sp_ready = 1'b0, pk_ready = 1'b0, bd_ready = 1'b1;
  logic [31:0] sp_tag, sp_idx, pk_tag, pk_idx, bd_tag, bd_idx;
  logic        sp_done, pk_done, bd_done;
  logic        sp_err, pk_err, bd_err;

  int n_chk = 0, n_fail = 0;
  int sp_done_cnt = 0, pk_done_cnt = 0, bd_done_cnt = 0;
  int sp_done_exp = 0, pk_done_exp = 0;
  int cyc = 0;
  logic [63:0] q_sp[$], q_pk[$];
  bit   sp_stall = 0, pk_stall = 0;
  logic [63:0] sp_held, pk_held;

  always #2 clk = ~clk;

  inv_line_seq #(.WAY_PAGE_RATIO(4), .PACKED_IDX(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(sp_rdy_req),
    .req_paddr_i(req_paddr), .req_size_i(req_size), .req_vaddr_valid_i(req_vv),
    .req_vaddr_i(req_vaddr), .cmd_valid_o(sp_valid), .cmd_ready_i(sp_ready),
    .cmd_tag_o(sp_tag), .cmd_index_o(sp_idx), .done_o(sp_done), .cfg_err_o(sp_err));

  inv_line_seq #(.WAY_PAGE_RATIO(2), .PACKED_IDX(1'b1)) u_dut_pk (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(pk_rdy_req),
    .req_paddr_i(req_paddr), .req_size_i(req_size), .req_vaddr_valid_i(req_vv),
    .req_vaddr_i(req_vaddr), .cmd_valid_o(pk_valid), .cmd_ready_i(pk_ready),
    .cmd_tag_o(pk_tag), .cmd_index_o(pk_idx), .done_o(pk_done), .cfg_err_o(pk_err));

  inv_line_seq #(.WAY_PAGE_RATIO(3), .PACKED_IDX(1'b0)) u_dut_bad (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(bd_rdy_req),
    .req_paddr_i(req_paddr), .req_size_i(req_size), .req_vaddr_valid_i(req_vv),
    .req_vaddr_i(req_vaddr), .cmd_valid_o(bd_valid), .cmd_ready_i(bd_ready),
    .cmd_tag_o(bd_tag), .cmd_index_o(bd_idx), .done_o(bd_done), .cfg_err_o(bd_err));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected stream from the requirements (split ratio 4, packed ratio 2)
  task automatic push_exp(input logic [31:0] pa, input int sz, input bit vv, input logic [31:0] va);
    logic [31:0] start, la, a;
    int slack, n;
    start = pa & ~32'h1f;
    slack = int'(pa & 32'h1f);
    n = (sz == 0) ? 0 : (sz + slack + 31) / 32;
    for (int l = 0; l < n; l++) begin
      la = start + 32'(l * 32);
      if (vv) begin
        q_sp.push_back({la, (va & ~32'h1f) + 32'(l * 32)});
        a = la | ((va >> 13) & 32'h1f);
        q_pk.push_back({a, a});
      end else begin
        for (int v = 0; v < 4; v++)
          q_sp.push_back({la, (la & ~32'h6000) | (32'(v) << 13)});
        for (int v = 0; v < 2; v++)
          q_pk.push_back({la | 32'(v), la | 32'(v)});
      end
    end
    sp_done_exp++;
    pk_done_exp++;
  endtask

  // monitor: owns the command ready lines, compares on handshake
  always @(negedge clk) begin
    logic [63:0] e;
    cyc++;
    if (rst_ni) begin
      if (sp_stall && sp_valid) chk({sp_tag, sp_idx} == sp_held, "R9", "split held cmd", {sp_tag, sp_idx}, sp_held);
      if (pk_stall && pk_valid) chk({pk_tag, pk_idx} == pk_held, "R9", "packed held cmd", {pk_tag, pk_idx}, pk_held);
      sp_ready = (cyc % 3) != 0;
      pk_ready = (cyc % 4) != 1;
      sp_stall = sp_valid && !sp_ready;
      pk_stall = pk_valid && !pk_ready;
      sp_held = {sp_tag, sp_idx};
      pk_held = {pk_tag, pk_idx};
      if (sp_valid && sp_ready) begin
        if (q_sp.size() == 0) chk(1'b0, "R7", "unexpected split cmd", {sp_tag, sp_idx}, 64'd0);
        else begin
          e = q_sp.pop_front();
          chk({sp_tag, sp_idx} == e, "R3/R5", "split cmd", {sp_tag, sp_idx}, e);
        end
      end
      if (pk_valid && pk_ready) begin
        if (q_pk.size() == 0) chk(1'b0, "R7", "unexpected packed cmd", {pk_tag, pk_idx}, 64'd0);
        else begin
          e = q_pk.pop_front();
          chk({pk_tag, pk_idx} == e, "R4/R5", "packed cmd", {pk_tag, pk_idx}, e);
        end
      end
      if (bd_valid) chk(1'b0, "R10", "cmd from bad ratio", {bd_tag, bd_idx}, 64'd0);
      if (sp_done) begin
        sp_done_cnt++;
        chk(q_sp.size() == 0, "R8", "split done with pending", 64'(q_sp.size()), 64'd0);
      end
      if (pk_done) begin
        pk_done_cnt++;
        chk(q_pk.size() == 0, "R8", "packed done with pending", 64'(q_pk.size()), 64'd0);
      end
      if (bd_done) bd_done_cnt++;
    end
  end

  task automatic run_req(input logic [31:0] pa, input int sz, input bit vv,
                         input logic [31:0] va, input bit stray, input string tag);
    while (!(sp_rdy_req && pk_rdy_req && bd_rdy_req)) @(negedge clk);
    push_exp(pa, sz, vv, va);
    req_paddr = pa; req_size = 16'(sz); req_vv = vv; req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (stray) begin
      req_paddr = 32'hdead_bee0; req_size = 16'd64; req_vv = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!(sp_rdy_req && pk_rdy_req)) @(negedge clk);
    @(negedge clk);
    chk(q_sp.size() == 0, tag, "split queue drained", 64'(q_sp.size()), 64'd0);
    chk(q_pk.size() == 0, tag, "packed queue drained", 64'(q_pk.size()), 64'd0);
    chk(sp_done_cnt == sp_done_exp, "R8", "split done count", 64'(sp_done_cnt), 64'(sp_done_exp));
    chk(pk_done_cnt == pk_done_exp, "R8", "packed done count", 64'(pk_done_cnt), 64'(pk_done_exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(sp_rdy_req == 1'b1, "R7", "idle after reset", 64'(sp_rdy_req), 64'd1);
    chk(sp_valid == 1'b0, "R7", "no cmd after reset", 64'(sp_valid), 64'd0);
    chk(sp_done == 1'b0, "R8", "no done after reset", 64'(sp_done), 64'd0);
    chk(sp_err == 1'b0 && pk_err == 1'b0, "R10", "legal ratios no error", 64'(sp_err | pk_err), 64'd0);
    chk(bd_err == 1'b1, "R10", "ratio 3 flags error", 64'(bd_err), 64'd1);

    run_req(32'h0001_0000, 64, 0, 0, 0, "R2");          // aligned, two lines
    run_req(32'h1234_5678, 8, 0, 0, 0, "R1");           // ends exactly on a line boundary
    run_req(32'h1234_5678, 9, 0, 0, 0, "R1");           // spills one byte
    run_req(32'h0000_6040, 32, 0, 0, 0, "R3");          // page-shift bits already set
    run_req(32'h0004_2010, 100, 1, 32'h0003_a7f0, 0, "R5");
    run_req(32'h0000_0000, 0, 0, 0, 0, "R6");           // zero size
    run_req(32'h0008_0003, 200, 0, 0, 1, "R7");         // stray request while busy
    run_req(32'h0ff0_7fe1, 31, 1, 32'h0007_e000, 0, "R5");
    run_req(32'h0000_0000, 0, 1, 32'h1234_0000, 0, "R6");
    run_req(32'h0002_3fff, 2, 0, 0, 0, "R4");

    chk(bd_done_cnt > 0, "R10", "bad ratio still completes", 64'(bd_done_cnt), 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule